// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two 8-bit two's-complement operands and returns their full 16-bit signed product. The multiplier operand is recoded into signed radix-4 digits, one for each pair of its bits. Each digit is in the range -2 to +2 and selects zero, the multiplicand, or twice the multiplicand, with optional negation. This halves the number of partial product rows compared with a plain bit-by-bit array.

The rows are summed by a chain of 3:2 carry-save counters. The negation correction bits and the sign-extension constant share one extra row in that chain. A carry-select adder then resolves the redundant sum into the product.

The combinational path is bounded by one register stage on the operands and one on the product. A new operand pair can be accepted every cycle. Each result appears two clock edges after its operands are sampled.

Top module: `booth4_mult`

## Requirements
- R1: For every pair of 8-bit signed operands, `p_o` equals their exact product as a 16-bit two's-complement value.
- R2: Operands present at clock edge k appear on `p_o` after edge k+1. `p_o` keeps its old value after edge k and holds the new value while the operands stay unchanged.
- R3: When `rst_ni` is low, both register stages are cleared at once, without waiting for a clock edge, and `p_o` reads 0.
- R4: If either operand is zero, the product is 0.
- R5: If both operands are nonzero, `p_o[15]` is 1 exactly when one operand is negative and the other is not.
- R6: (-128) x (-128) gives +16384 (0x4000), with no overflow.
- R7: 127 x (-128) and (-128) x 127 both give -16256 (0xC080).
- R8: A multiplier of -1 (0xFF) gives the negated multiplicand, including (-128) x (-1) = +128 (0x0080).
- R9: Operand pairs changed on every cycle produce one correct product per cycle, with no bubbles between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Multiplicand, two's complement |
| b_i | input | 8 | Multiplier (recoded operand), two's complement |
| p_o | output | 16 | Registered signed product |

## Verification
The assertions assume that the operands are valid whenever they are sampled. They only compare products whose operands were captured after reset was released. A counter in the checker holds back the product, sign and hold properties until enough edges have passed since reset.

The stimulus changes the operands only on falling clock edges, so every sampled value is well defined. It releases reset with the operands at zero. It then sweeps every operand pair back to back, runs a table of corner cases, and applies directed pairs for the exact boundary products.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } digit_t;

  // triple = {b[2i+1], b[2i], b[2i-1]}
  function automatic digit_t recode(input logic [2:0] t);
    digit_t d;
    unique case (t)
      3'b000, 3'b111: d = '{neg: 1'b0, one: 1'b0, two: 1'b0};
      3'b001, 3'b010: d = '{neg: 1'b0, one: 1'b1, two: 1'b0};
      3'b011:         d = '{neg: 1'b0, one: 1'b0, two: 1'b1};
      3'b100:         d = '{neg: 1'b1, one: 1'b0, two: 1'b1};
      default:        d = '{neg: 1'b1, one: 1'b1, two: 1'b0};
    endcase
    return d;
  endfunction

  // sum of -2^(w+2i) over all rows, modulo 2^(2w)
  function automatic logic [31:0] sign_const(input int w, input int rows);
    logic [31:0] k;
    k = '0;
    for (int i = 0; i < rows; i++) k = k - (32'd1 << (w + 2 * i));
    return k;
  endfunction

endpackage

// File: rtl/booth4_enc.sv
module booth4_enc
  import booth4_pkg::*;
#(
  parameter int W = 8,
  localparam int NPP = W / 2
) (
  input  logic [W-1:0] b_i,
  output digit_t       dig_o [NPP]
);
  logic [W:0] b_ext;
  assign b_ext = {b_i, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_dig
    assign dig_o[i] = recode(b_ext[2*i+2 -: 3]);
  end
endmodule

// File: rtl/booth4_row.sv
module booth4_row
  import booth4_pkg::*;
#(
  parameter int W   = 8,
  parameter int IDX = 0,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  digit_t        dig_i,
  output logic [PW-1:0] row_o
);
  logic [W:0] sel, pp, ext;

  always_comb begin
    if (dig_i.two)      sel = {a_i, 1'b0};
    else if (dig_i.one) sel = {a_i[W-1], a_i};
    else                sel = '0;
    pp  = sel ^ {(W+1){dig_i.neg}};
    // inverted sign; the matching -2^(W+2i) lives in the shared constant
    ext = {~pp[W], pp[W-1:0]};
  end

  assign row_o = {{(PW-W-1){1'b0}}, ext} << (2 * IDX);
endmodule

// File: rtl/booth4_csa.sv
module booth4_csa #(
  parameter int PW   = 16,
  parameter int NROW = 5,
  localparam int NST = NROW - 2
) (
  input  logic [PW-1:0] rows_i [NROW],
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] cry_o
);
  logic [PW-1:0] s [NST];
  logic [PW-1:0] c [NST];

  for (genvar k = 0; k < NST; k++) begin : g_st
    logic [PW-1:0] x, y, z, maj;
    if (k == 0) begin : g_first
      assign x = rows_i[0];
      assign y = rows_i[1];
    end else begin : g_next
      assign x = s[k-1];
      assign y = c[k-1];
    end
    assign z    = rows_i[k+2];
    assign s[k] = x ^ y ^ z;
    assign maj  = (x & y) | (x & z) | (y & z);
    assign c[k] = {maj[PW-2:0], 1'b0};
  end

  assign sum_o = s[NST-1];
  assign cry_o = c[NST-1];
endmodule

// File: rtl/booth4_csel.sv
module booth4_csel #(
  parameter int W   = 16,
  parameter int SEC = 4,
  localparam int NSEC = W / SEC
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [NSEC:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    logic [SEC-1:0] xa, xb;
    assign xa = a_i[i*SEC +: SEC];
    assign xb = b_i[i*SEC +: SEC];
    if (i == 0) begin : g_lsb
      assign {cy[1], s_o[SEC-1:0]} = {1'b0, xa} + {1'b0, xb};
    end else begin : g_sel
      logic [SEC:0] r0, r1;
      assign r0 = {1'b0, xa} + {1'b0, xb};
      assign r1 = {1'b0, xa} + {1'b0, xb} + {{SEC{1'b0}}, 1'b1};
      assign s_o[i*SEC +: SEC] = cy[i] ? r1[SEC-1:0] : r0[SEC-1:0];
      assign cy[i+1]           = cy[i] ? r1[SEC] : r0[SEC];
    end
  end
endmodule

// File: rtl/booth4_mult.sv
module booth4_mult
  import booth4_pkg::*;
#(
  parameter int W   = 8,
  parameter int SEC = 4,
  localparam int PW   = 2 * W,
  localparam int NPP  = W / 2,
  localparam int NROW = NPP + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] p_o
);
  localparam logic [31:0] K32 = sign_const(W, NPP);
  localparam logic [PW-1:0] SIGN_K = K32[PW-1:0];

  logic [W-1:0]  a_q, b_q;
  digit_t        dig [NPP];
  logic [PW-1:0] rows [NROW];
  logic [PW-1:0] fix_row, csa_s, csa_c, p_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  booth4_enc #(.W(W)) i_enc (.b_i(b_q), .dig_o(dig));

  for (genvar i = 0; i < NPP; i++) begin : g_row
    booth4_row #(.W(W), .IDX(i)) i_row (
      .a_i(a_q), .dig_i(dig[i]), .row_o(rows[i])
    );
  end

  // negation +1 bits sit below bit W, where the constant is all zero
  always_comb begin
    fix_row = SIGN_K;
    for (int i = 0; i < NPP; i++) fix_row[2*i] = dig[i].neg;
  end
  assign rows[NPP] = fix_row;

  booth4_csa #(.PW(PW), .NROW(NROW)) i_csa (
    .rows_i(rows), .sum_o(csa_s), .cry_o(csa_c)
  );

  booth4_csel #(.W(PW), .SEC(SEC)) i_cpa (
    .a_i(csa_s), .b_i(csa_c), .s_o(p_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= p_d;
  end
endmodule

// File: rtl/booth4_mult_chk.sv
module booth4_mult_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  a_i,
  input logic [7:0]  b_i,
  input logic [15:0] p_o
);
  logic [1:0]        cnt;
  logic signed [15:0] ref1, ref2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      ref1 <= '0;
      ref2 <= '0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      ref1 <= $signed({{8{a_i[7]}}, a_i}) * $signed({{8{b_i[7]}}, b_i});
      ref2 <= ref1;
    end
  end

  AST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt >= 2'd2) |-> (p_o == ref2)) else $error("product");  // R1

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (p_o == 16'd0)) else $error("reset");  // R3

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt >= 2'd2) && (($past(a_i, 2) == 8'd0) || ($past(b_i, 2) == 8'd0)))
    |-> (p_o == 16'd0)) else $error("zero");  // R4

  AST_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt >= 2'd2) && ($past(a_i, 2) != 8'd0) && ($past(b_i, 2) != 8'd0))
    |-> (p_o[15] == ($past(a_i[7], 2) ^ $past(b_i[7], 2)))) else $error("sign");  // R5

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt == 2'd3) && ($past(a_i, 2) == $past(a_i, 3))
     && ($past(b_i, 2) == $past(b_i, 3))) |-> $stable(p_o)) else $error("hold");  // R2
endmodule

bind booth4_mult booth4_mult_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o)
);

// File: tb/test_booth4_mult.sv
module test_booth4_mult;
  localparam int CLK_NS = 20;
  localparam int NVEC   = 19;
  // {a, b, expected product}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 16'h0000}, {8'h00, 8'h01, 16'h0000},
    {8'h01, 8'h00, 16'h0000}, {8'h01, 8'h01, 16'h0001},
    {8'h01, 8'h02, 16'h0002}, {8'h02, 8'h01, 16'h0002},
    {8'h01, 8'h80, 16'hFF80}, {8'h80, 8'h01, 16'hFF80},
    {8'h01, 8'h7F, 16'h007F}, {8'h7F, 8'h01, 16'h007F},
    {8'h7F, 8'h7F, 16'h3F01}, {8'h80, 8'h80, 16'h4000},
    {8'h7F, 8'h80, 16'hC080}, {8'h80, 8'h7F, 16'hC080},
    {8'hFF, 8'hFF, 16'h0001}, {8'hFF, 8'h80, 16'h0080},
    {8'h80, 8'hFF, 16'h0080}, {8'h55, 8'hAA, 16'hE372},
    {8'h02, 8'hFE, 16'hFFFC}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [15:0] p_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_NS / 2) clk = ~clk;

  booth4_mult i_booth4_mult (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o)
  );

  function automatic logic [15:0] sref(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] r;
    r = $signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b});
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    a_i = a;
    b_i = b;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R3 reset", p_o, 16'h0000);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // corner table, then an exhaustive back-to-back sweep (R1, R9)
    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][31:24], VEC[k][23:16]);
      chk("R1 table", p_o, VEC[k][15:0]);
    end
    for (int k = 0; k < 65538; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        logic [15:0] prev;
        prev = 16'(k - 2);
        chk("R9 stream", p_o, sref(prev[15:8], prev[7:0]));
      end
      if (k < 65536) begin
        logic [15:0] cur;
        cur = 16'(k);
        a_i = cur[15:8];
        b_i = cur[7:0];
      end
    end

    apply(8'h80, 8'h80);  chk("R6", p_o, 16'h4000);
    apply(8'h7F, 8'h80);  chk("R7", p_o, 16'hC080);
    apply(8'h80, 8'h7F);  chk("R7", p_o, 16'hC080);
    apply(8'h80, 8'hFF);  chk("R8", p_o, 16'h0080);
    apply(8'h39, 8'hFF);  chk("R8", p_o, 16'hFFC7);
    apply(8'h80, 8'h00);  chk("R4", p_o, 16'h0000);
    apply(8'h00, 8'h93);  chk("R4", p_o, 16'h0000);
    apply(8'hFD, 8'h05);  chk("R5", {15'd0, p_o[15]}, 16'd1);
    apply(8'hFD, 8'hFB);  chk("R5", {15'd0, p_o[15]}, 16'd0);

    // latency and hold: 3 x 4 = 12 follows 0x7F x 0x7F
    apply(8'h7F, 8'h7F);
    @(negedge clk);
    a_i = 8'h03; b_i = 8'h04;
    @(negedge clk);
    chk("R2 old value after one edge", p_o, 16'h3F01);
    @(negedge clk);
    chk("R2 new value after two edges", p_o, 16'h000C);
    repeat (3) @(negedge clk);
    chk("R2 held", p_o, 16'h000C);

    // asynchronous clear mid-cycle, held with live operands
    #2 rst_ni = 1'b0;
    #1 chk("R3 async clear", p_o, 16'h0000);
    @(negedge clk);
    chk("R3 held in reset", p_o, 16'h0000);
    a_i = '0; b_i = '0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 after release", p_o, 16'h0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule